// File: doc/BRIEF.md
# Edge-Triggered Timer Capture Unit

This block records when signal edges happen. Two asynchronous input pins are watched for rising and falling transitions. Each pin has one capture register for its rising edges and another for its falling edges, so four capture slots exist in total. When a qualifying edge is detected, the matching slot stores an eight-bit slice of a shared free-running timer.

A small prescale setting chooses which eight-bit window of the timer is stored. Shifting the window toward the upper timer bits trades resolution for the length of interval that can be measured. Each slot has a sticky event flag. A per-slot enable decides whether that flag drives an interrupt request line.

Software reaches the block through a simple register port. Writes take effect on the clock edge and reads are combinational. The timer itself and the interrupt controller sit outside this block.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset every capture slot, the prescale code, the interrupt enables and the event flags read as zero, and all interrupt lines are low.
- R2: Capture slots map to addresses as follows: pin 0 rising at address 0, pin 0 falling at address 1, pin 1 rising at address 2, and pin 1 falling at address 3. A pin level first sampled at clock edge k loads its slot at edge k+2, with the timer value present at that edge.
- R3: An edge loads only the slot whose direction matches it. The slot of the opposite direction and the slots of the other pin keep their contents.
- R4: The prescale code p is written at address 4, bits [1:0]. A capture stores timer bits [p+7:p]. The code in force before a write's edge applies to a capture on that same edge.
- R5: Each new matching edge overwrites the slot's previous value.
- R6: Capture slots are read-only. Writes to addresses 0 to 3 leave them unchanged.
- R7: A capture sets the slot's event flag, which is read at address 6, bit i for slot i. The flag stays set until a write of 1 to that bit at address 6 clears it. A capture on the same edge as the clear leaves the flag set.
- R8: Interrupt enables are held at address 5, bit i for slot i. irq_o[i] is high exactly when flag i and enable i are both set. Flags still set while their enable is clear.
- R9: Address 7 and all unused register bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_i | input | 12 | Free-running timer value |
| cap_pin_i | input | 2 | Asynchronous edge inputs, pin 0 and pin 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| irq_o | output | 4 | Per-slot interrupt requests |

## Verification
A wrong slot index, window shift or edge polarity shows up on reg_rdata_o two clock edges after the offending pin change, as soon as that slot is addressed. A broken flag or enable path shows up on irq_o one cycle after the capture or the register write. Because the bench compares every readable register and every interrupt line against its own model on each cycle, a corrupted internal state is visible at the ports no later than the next read of the affected address.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;

  // Direction pair produced by one pin's edge detector
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  // Offset of the falling-edge slot relative to the rising-edge slot of a pin
  localparam int FALL_OFS = 1;
  localparam int SLOTS_PER_PIN = 2;

endpackage

// File: rtl/cap_pin_sync.sv
module cap_pin_sync
  import edge_cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_i,
  output edge_t edge_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   level;

  assign level = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    prev_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    edge_o.rise = level & ~prev_q;
    edge_o.fall = ~level & prev_q;
  end

  AST_NO_BACK_TO_BACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o.rise |=> !edge_o.rise); // R2

  AST_NO_BACK_TO_BACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o.fall |=> !edge_o.fall); // R2

endmodule

// File: rtl/cap_window.sv
module cap_window #(
  parameter int TMR_W = 12,
  parameter int CAP_W = 8,
  parameter int PSC_W = 2
) (
  input  logic [TMR_W-1:0] timer_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic [CAP_W-1:0] win_o
);

  localparam int TOP_BIT = CAP_W + (1 << PSC_W) - 2;

  initial begin
    if (TOP_BIT >= TMR_W) $error("prescale window exceeds timer width");
  end

  always_comb begin
    win_o = CAP_W'(timer_i >> psc_i);
  end

endmodule

// File: rtl/cap_slot.sv
module cap_slot #(
  parameter int CAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_stb_i,
  input  logic [CAP_W-1:0] cap_val_i,
  input  logic             clr_i,
  output logic [CAP_W-1:0] data_o,
  output logic             flag_o
);

  logic [CAP_W-1:0] data_q;
  logic             flag_q, flag_d;

  always_comb begin
    flag_d = (flag_q & ~clr_i) | cap_stb_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_stb_i) begin
      data_q <= cap_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign data_o = data_q;
  assign flag_o = flag_q;

  AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb_i |=> flag_q); // R7

  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cap_stb_i)); // R7

  AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb_i |=> $stable(data_q)); // R3

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import edge_cap_pkg::*;
#(
  parameter int TMR_W       = 12,
  parameter int CAP_W       = 8,
  parameter int PSC_W       = 2,
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_SLOTS  = SLOTS_PER_PIN * NUM_PINS,
  localparam int ADDR_W     = $clog2(NUM_SLOTS + 4)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TMR_W-1:0]     timer_i,
  input  logic [NUM_PINS-1:0]  cap_pin_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [CAP_W-1:0]     reg_wdata_i,
  output logic [CAP_W-1:0]     reg_rdata_o,
  output logic [NUM_SLOTS-1:0] irq_o
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int A_PSC  = NUM_SLOTS;
  localparam int A_IEN  = NUM_SLOTS + 1;
  localparam int A_FLG  = NUM_SLOTS + 2;

  logic [PSC_W-1:0]     psc_q, psc_d;
  logic [NUM_SLOTS-1:0] ien_q, ien_d;
  logic [NUM_SLOTS-1:0] flag, stb, clr;
  logic [CAP_W-1:0]     cap_val;
  logic [CAP_W-1:0]     cap_data [NUM_SLOTS];
  edge_t                pin_edge [NUM_PINS];
  logic                 wr_psc, wr_ien, wr_flg, addr_is_slot;
  logic                 unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  assign wr_psc       = reg_we_i && (reg_addr_i == ADDR_W'(A_PSC));
  assign wr_ien       = reg_we_i && (reg_addr_i == ADDR_W'(A_IEN));
  assign wr_flg       = reg_we_i && (reg_addr_i == ADDR_W'(A_FLG));
  assign addr_is_slot = (reg_addr_i < ADDR_W'(NUM_SLOTS));

  cap_window #(
    .TMR_W (TMR_W),
    .CAP_W (CAP_W),
    .PSC_W (PSC_W)
  ) u_window (
    .timer_i (timer_i),
    .psc_i   (psc_q),
    .win_o   (cap_val)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    cap_pin_sync #(
      .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (cap_pin_i[g]),
      .edge_o (pin_edge[g])
    );
    assign stb[SLOTS_PER_PIN*g]            = pin_edge[g].rise;
    assign stb[SLOTS_PER_PIN*g + FALL_OFS] = pin_edge[g].fall;
  end

  assign clr = {NUM_SLOTS{wr_flg}} & reg_wdata_i[NUM_SLOTS-1:0];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    cap_slot #(
      .CAP_W (CAP_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_stb_i (stb[s]),
      .cap_val_i (cap_val),
      .clr_i     (clr[s]),
      .data_o    (cap_data[s]),
      .flag_o    (flag[s])
    );

    AST_CAPTURE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      stb[s] |=> (cap_data[s] == $past(cap_val))); // R4

    AST_SLOT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_i && reg_addr_i == ADDR_W'(s) && !stb[s]) |=> $stable(cap_data[s])); // R6

    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (stb[s] && ien_q[s] && !wr_ien) |=> irq_o[s]); // R8
  end

  // Configuration next state
  always_comb begin
    psc_d = psc_q;
    ien_d = ien_q;
    if (wr_psc) psc_d = reg_wdata_i[PSC_W-1:0];
    if (wr_ien) ien_d = reg_wdata_i[NUM_SLOTS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      ien_q <= '0;
    end else begin
      psc_q <= psc_d;
      ien_q <= ien_d;
    end
  end

  assign irq_o = flag & ien_q;

  // Read-back multiplexer
  always_comb begin
    reg_rdata_o = '0;
    if (addr_is_slot) begin
      reg_rdata_o = cap_data[reg_addr_i[SLOT_W-1:0]];
    end else if (reg_addr_i == ADDR_W'(A_PSC)) begin
      reg_rdata_o = CAP_W'(psc_q);
    end else if (reg_addr_i == ADDR_W'(A_IEN)) begin
      reg_rdata_o = CAP_W'(ien_q);
    end else if (reg_addr_i == ADDR_W'(A_FLG)) begin
      reg_rdata_o = CAP_W'(flag);
    end
  end

  AST_NO_IRQ_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ien && reg_wdata_i[NUM_SLOTS-1:0] == '0) |=> (irq_o == '0)); // R8

endmodule

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] timer;
  logic [1:0]  pins;
  logic        we;
  logic [2:0]  addr;
  logic [7:0]  wdata;
  wire  [7:0]  rdata;
  wire  [3:0]  irq;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 0;

  // Behavioural reference state
  int m_cap [4];
  int m_psc, m_ien, m_flg;
  bit hq0 [$];
  bit hq1 [$];

  always #10 clk = ~clk;

  edge_capture_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .timer_i     (timer),
    .cap_pin_i   (pins),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic int exp_rd(int a);
    if (a < 4)  return m_cap[a];
    if (a == 4) return m_psc;
    if (a == 5) return m_ien;
    if (a == 6) return m_flg;
    return 0;
  endfunction

  function automatic string tag_of(int a);
    if (a < 4)  return "R2";
    if (a == 4) return "R4";
    if (a == 5) return "R8";
    if (a == 6) return "R7";
    return "R9";
  endfunction

  // Reference model: a level seen at edge k produces a capture at edge k+2
  always @(posedge clk) begin
    int set, val;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_cap[i] = 0;
      m_psc = 0; m_ien = 0; m_flg = 0;
      hq0 = '{0, 0, 0};
      hq1 = '{0, 0, 0};
    end else begin
      set = 0;
      val = (int'(timer) >> m_psc) & 255;
      if (hq0[1] && !hq0[2]) begin m_cap[0] = val; set |= 1; end
      if (!hq0[1] && hq0[2]) begin m_cap[1] = val; set |= 2; end
      if (hq1[1] && !hq1[2]) begin m_cap[2] = val; set |= 4; end
      if (!hq1[1] && hq1[2]) begin m_cap[3] = val; set |= 8; end
      hq0.push_front(pins[0]); void'(hq0.pop_back());
      hq1.push_front(pins[1]); void'(hq1.pop_back());
      if (we) begin
        if (addr == 4) m_psc = wdata & 3;
        if (addr == 5) m_ien = wdata & 15;
        if (addr == 6) m_flg = m_flg & ~int'(wdata);
      end
      m_flg = (m_flg & 15) | set;
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (int'(rdata) != exp_rd(int'(addr))) begin
        fails++;
        $display("FAIL %s addr %0d: rdata %0h expected %0h", tag_of(int'(addr)), addr, rdata, exp_rd(int'(addr)));
      end
      if (int'(irq) != (m_flg & m_ien)) begin
        fails++;
        $display("FAIL R8 irq %0h expected %0h", irq, m_flg & m_ien);
      end
    end
  end

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      summary();
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input int expv, input string tag);
    addr = a;
    @(negedge clk);
    vectors++;
    if (int'(rdata) != expv) begin
      fails++;
      $display("FAIL %s addr %0d: rdata %0h expected %0h", tag, a, rdata, expv);
    end
    tick();
  endtask

  task automatic chk_irq(input int expv, input string tag);
    @(negedge clk);
    vectors++;
    if (int'(irq) != expv) begin
      fails++;
      $display("FAIL %s irq %0h expected %0h", tag, irq, expv);
    end
    tick();
  endtask

  initial begin
    rst_n = 1'b0; timer = '0; pins = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();

    // R1: everything clear after reset
    for (int a = 0; a < 7; a++) chk(3'(a), 0, "R1");
    chk_irq(0, "R1");

    // R2: pin 0 rising edge, prescale 0
    timer = 12'hABC;
    pins[0] = 1'b1;
    repeat (4) tick();
    chk(3'd0, 8'hBC, "R2");
    chk(3'd1, 0, "R3");
    chk(3'd6, 1, "R7");

    // R4: prescale 2 on pin 0 falling edge
    wr(3'd4, 8'h02);
    chk(3'd4, 2, "R4");
    timer = 12'h5A7;
    pins[0] = 1'b0;
    repeat (4) tick();
    chk(3'd1, 8'h69, "R4");
    chk(3'd0, 8'hBC, "R3");

    // R4: prescale 3 on pin 1 rising edge
    wr(3'd4, 8'h03);
    timer = 12'hF0F;
    pins[1] = 1'b1;
    repeat (4) tick();
    chk(3'd2, 8'hE1, "R4");
    chk(3'd3, 0, "R3");

    // R6: writes to a capture slot are ignored
    wr(3'd0, 8'h55);
    chk(3'd0, 8'hBC, "R6");

    // R5: new rising edge on pin 0 overwrites
    wr(3'd4, 8'h01);
    timer = 12'h3FE;
    pins[0] = 1'b1;
    repeat (4) tick();
    chk(3'd0, 8'hFF, "R5");

    // R8: flags set while disabled, irq follows enable
    chk(3'd6, 7, "R8");
    chk_irq(0, "R8");
    wr(3'd5, 8'h05);
    chk_irq(5, "R8");

    // R7: write-one-to-clear
    wr(3'd6, 8'h01);
    chk(3'd6, 6, "R7");
    chk_irq(4, "R7");

    // R7: capture on the same edge as a clear keeps the flag
    timer = 12'h9C4;
    pins[1] = 1'b0;
    tick();
    tick();
    wr(3'd6, 8'h08);
    chk(3'd6, 8'h0E, "R7");
    chk(3'd3, 8'hE2, "R2");

    // R9: unused address reads zero
    chk(3'd7, 0, "R9");

    // Mixed traffic against the reference model
    for (int n = 0; n < 3000; n++) begin
      timer = 12'($urandom);
      if ($urandom_range(5) == 0) pins[0] = ~pins[0];
      if ($urandom_range(5) == 0) pins[1] = ~pins[1];
      addr  = 3'($urandom);
      we    = ($urandom_range(7) == 0);
      wdata = 8'($urandom);
      tick();
    end
    we = 1'b0;
    tick();
    summary();
  end

endmodule